// File: doc/BRIEF.md
# Vector serializer with idle padding

This block accepts a wide vector of `NELEM` elements, each `EW` bits wide, and sends it out over several cycles in narrower chunks of `NELEM/RATIO` elements. Every frame lasts `RATIO + IDLE` clock cycles. The first `RATIO` cycles of a frame carry data chunks. The last `IDLE` cycles are padding, during which the data output is forced to zero.

The input vector and its valid flag are sampled once per frame, on the cycle where the frame counter is at zero. The data path runs on every frame, whatever the state of the valid flag. The valid flag only gates the two control outputs. When it is high, the start marker pulses on the first chunk of the frame, and the valid output covers all chunk cycles. A downstream collector can use the start marker to find where a vector begins.

Top module: `vec_serializer`

## Requirements
- R1: The chunk output is `(NELEM/RATIO)*EW` bits wide. A configuration where `NELEM` is not a multiple of `RATIO` is rejected at elaboration.
- R2: A frame lasts exactly `RATIO + IDLE` cycles. With `IDLE = 0`, the first chunk of a vector follows the last chunk of the previous vector on the next cycle.
- R3: Chunks leave in ascending element order. Chunk k carries elements `k*(NELEM/RATIO)` to `(k+1)*(NELEM/RATIO)-1`. Element 0 occupies the least significant bits of `din` and of the chunk.
- R4: The chunk sequence depends only on the sampled vector and is identical whether the sampled valid flag is high or low.
- R5: With the sampled flag high, `start_o` is high on the first chunk cycle of the frame only.
- R6: With the sampled flag high, `valid_o` is high on all `RATIO` chunk cycles and low on every padding cycle.
- R7: With the sampled flag low, `start_o` and `valid_o` stay low for the whole frame.
- R8: On padding cycles, `dout` is zero.
- R9: A synchronous active-high reset clears the outputs to zero and restarts the frame. The cycle after reset is released is a frame boundary.
- R10: `din` and `vin` are sampled only at the frame boundary. Changes to them during the rest of the frame have no effect on that frame.
- R11: Outputs are registered. The first chunk of a vector appears one cycle after the boundary edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | NELEM*EW | Input vector, element 0 in the low bits |
| vin | input | 1 | Valid flag for the vector sampled at the frame boundary |
| dout | output | (NELEM/RATIO)*EW | Current chunk, zero while padding |
| start_o | output | 1 | Marks the first chunk of a valid vector |
| valid_o | output | 1 | High while a chunk of a valid vector is on `dout` |

## Verification
The bench scrambles `din` and `vin` in the middle of frames. A design that resamples its input after the boundary would then emit wrong chunks or wrong flags. It alternates valid and invalid frames that carry the same vector. A data path that wrongly depends on the valid flag, or a valid output that leaks into the padding cycles, shows up as a chunk or flag mismatch. A second instance with no padding and two-element chunks runs frames back to back, which exposes an off-by-one in the frame length or a chunk select that is wrong beyond the first element. A reset applied in the middle of a frame checks that the frame restarts cleanly instead of continuing from its old phase.

// File: rtl/vec_serializer.sv
module vec_serializer #(
  parameter int EW    = 8,
  parameter int NELEM = 4,
  parameter int RATIO = 4,
  parameter int IDLE  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NELEM*EW-1:0]           din,
  input  logic                          vin,
  output logic [(NELEM/RATIO)*EW-1:0]   dout,
  output logic                          start_o,
  output logic                          valid_o
);
  localparam int CHW   = (NELEM / RATIO) * EW;
  localparam int FRAME = RATIO + IDLE;
  localparam int CW    = (FRAME > 1) ? $clog2(FRAME) : 1;

  generate
    if ((NELEM % RATIO) != 0 || RATIO < 1 || IDLE < 0) begin : g_bad_cfg
      $error("vec_serializer: NELEM must be a multiple of RATIO (R1)");
    end
  endgenerate

  logic [CW-1:0]       cnt;
  logic [NELEM*EW-1:0] hold;
  logic                vflag;
  wire                 at_end = (int'(cnt) == FRAME - 1);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (at_end)  cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      vflag   <= 1'b0;
      dout    <= '0;
      start_o <= 1'b0;
      valid_o <= 1'b0;
    end else if (cnt == '0) begin
      hold    <= din;
      vflag   <= vin;
      dout    <= din[CHW-1:0];
      start_o <= vin;
      valid_o <= vin;
    end else if (int'(cnt) < RATIO) begin
      dout    <= hold[int'(cnt)*CHW +: CHW];
      start_o <= 1'b0;
      valid_o <= vflag;
    end else begin
      dout    <= '0;
      start_o <= 1'b0;
      valid_o <= 1'b0;
    end
  end

  p_start_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    (FRAME > 1 && start_o) |=> !start_o);

  p_start_has_valid_r5: assert property (@(posedge clk) disable iff (rst)
    start_o |-> valid_o);

  p_pad_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (int'($past(cnt)) >= RATIO) |-> (!valid_o && !start_o));

  p_pad_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (int'($past(cnt)) >= RATIO) |-> (dout == '0));

  p_invalid_silent_r7: assert property (@(posedge clk) disable iff (rst)
    !vflag |-> (!start_o && !valid_o));

  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (!start_o && !valid_o && dout == '0 && cnt == '0));
endmodule

// File: tb/vec_serializer_tb_top.sv
module vec_serializer_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic        rst = 1'b1;
  logic [31:0] din = '0;
  logic        vin = 1'b0;
  logic [7:0]  dout;
  logic        start_o, valid_o;

  logic        rst_z = 1'b1;
  logic [63:0] din_z = '0;
  logic        vin_z = 1'b0;
  logic [15:0] dout_z;
  logic        start_z, valid_z;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  vec_serializer #(.EW(8), .NELEM(4), .RATIO(4), .IDLE(2)) dut_i (
    .clk(clk), .rst(rst), .din(din), .vin(vin),
    .dout(dout), .start_o(start_o), .valid_o(valid_o));

  vec_serializer #(.EW(8), .NELEM(8), .RATIO(4), .IDLE(0)) dut_z (
    .clk(clk), .rst(rst_z), .din(din_z), .vin(vin_z),
    .dout(dout_z), .start_o(start_z), .valid_o(valid_z));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one frame of dut_i starting at a negedge just before a boundary.
  task automatic t_frame(input logic [31:0] v, input bit vi, input bit scramble);
    din = v;
    vin = vi;
    for (int j = 0; j < 6; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (scramble && j < 5) begin
        din = ~v;
        vin = ~vi;
      end
      if (j < 4) begin
        chk("R3/R4/R10 chunk", 64'(dout), 64'(v[j*8 +: 8]));
        chk("R6/R7 valid", 64'(valid_o), 64'(vi));
        chk("R5/R7 start", 64'(start_o), 64'(vi && j == 0));
      end else begin
        chk("R8 pad data", 64'(dout), 64'h0);
        chk("R6 pad valid", 64'(valid_o), 64'h0);
        chk("R5 pad start", 64'(start_o), 64'h0);
      end
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 reset dout", 64'(dout), 64'h0);
    chk("R9 reset valid", 64'(valid_o), 64'h0);
    chk("R9 reset start", 64'(start_o), 64'h0);
    rst = 1'b0;
  endtask

  task automatic t_mid_reset;
    din = 32'hCAFE_F00D;
    vin = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_frame(32'h1357_9BDF, 1'b1, 1'b0);
  endtask

  // No padding, two elements per chunk, frames back to back (R2).
  task automatic t_back_to_back;
    logic [63:0] vecs [3];
    bit          vls  [3];
    vecs[0] = 64'h0807_0605_0403_0201; vls[0] = 1'b1;
    vecs[1] = 64'hF0E0_D0C0_B0A0_9080; vls[1] = 1'b0;
    vecs[2] = 64'h1122_3344_5566_7788; vls[2] = 1'b1;
    rst_z = 1'b1;
    repeat (2) @(negedge clk);
    rst_z = 1'b0;
    for (int f = 0; f < 3; f++) begin
      din_z = vecs[f];
      vin_z = vls[f];
      for (int j = 0; j < 4; j++) begin
        @(posedge clk);
        @(negedge clk);
        chk("R2/R3 b2b chunk", 64'(dout_z), 64'(vecs[f][j*16 +: 16]));
        chk("R2 b2b valid", 64'(valid_z), 64'(vls[f]));
        chk("R5 b2b start", 64'(start_z), 64'(vls[f] && j == 0));
      end
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_frame(32'h4433_2211, 1'b1, 1'b0);  // R11 first chunk one cycle after boundary
    t_frame(32'h4433_2211, 1'b0, 1'b0);  // R4 same data with valid low
    t_frame(32'hDEAD_BEEF, 1'b1, 1'b1);  // R10 scrambled mid-frame
    t_frame(32'h0102_0304, 1'b0, 1'b1);  // R7 with scrambled vin
    t_frame(32'hFFFF_FFFF, 1'b1, 1'b0);
    t_frame(32'h0000_0000, 1'b1, 1'b0);
    t_mid_reset();                        // R9 restart
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule